// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Model

This block models the control front end and storage of a synchronous burst static RAM with a 16-bit data path made of two bytes. On every rising clock edge it looks at two address strobes and three chip selects. From these it decides whether to capture a new address, step the running burst, deselect, or stay idle. Bursts are four beats long. The two low address bits count either in linear order or in interleaved (XOR) order, chosen by a static pin. The upper address bits stay fixed for the whole burst.

The write controls form three levels: a global write, a byte-group write gate, and per-byte enables. These are resolved on each access cycle into per-byte writes or a read. Read data is registered and appears one clock after the access cycle. An asynchronous output enable gates whether it is driven. The read bus is modelled as a data output plus a drive flag, and a low drive flag stands for a high-impedance bus.

Top module: `sbsram_ctl`

## Requirements
- R1: After reset no burst is active. A burst-advance pulse without a prior valid strobe produces no read, so `rd_drive` stays low.
- R2: On a clock edge where all three selects are active (`sel_main_n` low, `sel_hi` high, `sel_lo_n` low) and either strobe is low, `addr` is captured. If that cycle is a read, the word at `addr` appears on `rd_data` with `rd_drive` high after the next edge.
- R3: While `sel_main_n` is high, a low `stb_cpu_n` is ignored: no address is loaded and a burst in progress keeps its position.
- R4: A strobe edge (the controller strobe, or the processor strobe with `sel_main_n` low) with any select inactive deselects the block. Later `adv_n` pulses produce no reads until a valid strobe loads a new address.
- R5: With `order_ilv` low, each `adv_n` low edge without a strobe steps the two low address bits by +1 from the start value, wrapping within the aligned group of four.
- R6: With `order_ilv` high, beat k of a burst uses low address bits equal to start XOR k.
- R7: With `wr_all_n` low on an access cycle, both bytes are written from `wr_data`, whatever the other write controls are.
- R8: With `wr_all_n` high and `wr_gate_n` low, bit i of `wr_byte_n` low writes byte i (bit 0 = bits 7:0, bit 1 = bits 15:8), and the other byte keeps its old value.
- R9: An access cycle is a read when `wr_all_n` is high and either `wr_gate_n` is high or both `wr_byte_n` bits are high. A read stores nothing.
- R10: `rd_drive` follows `oe_n` without a clock: it is high only while `oe_n` is low and the last access was a read.
- R11: After a write access or a deselect, `rd_drive` is low on the following cycle.
- R12: Through a burst the upper address bits stay those captured at the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address, captured on a valid strobe |
| stb_cpu_n | input | 1 | Processor address strobe, active low, gated by `sel_main_n` |
| stb_ctl_n | input | 1 | Controller address strobe, active low, ungated |
| sel_main_n | input | 1 | Master select, active low |
| sel_hi | input | 1 | Select, active high |
| sel_lo_n | input | 1 | Select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_gate_n | input | 1 | Byte-write gate, active low |
| wr_byte_n | input | NBYTES | Per-byte write enables, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_data | input | NBYTES*BYTE_W | Write data |
| rd_data | output | NBYTES*BYTE_W | Registered read data |
| rd_drive | output | 1 | High when the read bus is driven, low means high impedance |

## Verification
The hardest situation to reach from the ports is a processor strobe that arrives while the master select is off in the middle of a burst. Its effect shows only on the beat after it, so the stimulus holds a burst open and slips in the blocked strobe with a different address. It then advances once and checks that the word comes from the old burst's next beat. The interleaved wrap is reached the same way, by starting a burst at an odd offset and walking all four beats over words written earlier with distinct values.

// File: rtl/sbsram_ctl.sv
module sbsram_ctl #(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 8,
  parameter int NBYTES  = 2,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     stb_cpu_n,
  input  logic                     stb_ctl_n,
  input  logic                     sel_main_n,
  input  logic                     sel_hi,
  input  logic                     sel_lo_n,
  input  logic                     adv_n,
  input  logic                     wr_all_n,
  input  logic                     wr_gate_n,
  input  logic [NBYTES-1:0]        wr_byte_n,
  input  logic                     order_ilv,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  output logic [NBYTES*BYTE_W-1:0] rd_data,
  output logic                     rd_drive
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               active_q, rd_q;
  logic [DATA_W-1:0]  rdata_q;

  wire strobe = (!stb_cpu_n && !sel_main_n) || !stb_ctl_n;
  wire sel_ok = !sel_main_n && sel_hi && !sel_lo_n;
  wire load   = strobe && sel_ok;
  wire step   = !strobe && !adv_n && active_q;
  wire access = load || step;

  wire [BURST_W-1:0] cnt_nx   = cnt_q + BURST_W'(1);
  wire [BURST_W-1:0] start_lo = base_q[BURST_W-1:0];
  wire [BURST_W-1:0] beat_lo  = order_ilv ? (start_lo ^ cnt_nx) : (start_lo + cnt_nx);
  wire [ADDR_W-1:0]  acc_addr = load ? addr : {base_q[ADDR_W-1:BURST_W], beat_lo};

  wire [NBYTES-1:0] be = !wr_all_n ? {NBYTES{1'b1}} : (!wr_gate_n ? ~wr_byte_n : '0);
  wire is_wr = access && (|be);
  wire is_rd = access && !(|be);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBYTES; i++)
      if (is_wr && be[i]) mem[acc_addr][i*BYTE_W +: BYTE_W] <= wr_data[i*BYTE_W +: BYTE_W];
    if (is_rd) rdata_q <= mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      rd_q <= is_rd;
      if (strobe) begin
        active_q <= sel_ok;
        if (sel_ok) begin
          base_q <= addr;
          cnt_q  <= '0;
        end
      end else if (step) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign rd_data  = rdata_q;
  assign rd_drive = rd_q && !oe_n;

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !sel_ok) |=> !active_q);
  // R5
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + BURST_W'(1)));
  // R12
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q));
  // R3
  cpu_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_cpu_n && sel_main_n && stb_ctl_n && adv_n) |=>
      ($stable(base_q) && $stable(cnt_q) && $stable(active_q)));
  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !rd_drive);
endmodule

// File: tb/sim_sbsram_ctl.sv
`timescale 1ns/1ps
module sim_sbsram_ctl;
  typedef struct packed {
    logic ps_n, cs_n, m_n, hi, lo_n, adv_n, gw_n, gate_n;
    logic [1:0] bw_n;
    logic ilv, oe_n;
    logic [5:0] a;
    logic [15:0] d;
    logic eoe;
    logic [15:0] ed;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    // R7 global write burst at 8..11
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,1'b0,6'd8, 16'h1111,1'b0,16'h0000,8'd7},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h2222,1'b0,16'h0000,8'd5},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h3333,1'b0,16'h0000,8'd5},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h4444,1'b0,16'h0000,8'd5},
    // R8 low byte only at 9
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,1'b0,1'b0,6'd9, 16'hABCD,1'b0,16'h0000,8'd8},
    // R9 gate low, no byte enables: read; R5 linear burst from 10
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,1'b0,1'b0,6'd10,16'h0000,1'b1,16'h3333,8'd9},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b1,16'h4444,8'd5},
    // R12 wrap stays in group
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b1,16'h1111,8'd12},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b1,16'h22CD,8'd8},
    // R2 processor strobe load; R6 interleaved 9,8,11,10
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,6'd9, 16'h0000,1'b1,16'h22CD,8'd2},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,6'd0, 16'h0000,1'b1,16'h1111,8'd6},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,6'd0, 16'h0000,1'b1,16'h4444,8'd6},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,6'd0, 16'h0000,1'b1,16'h3333,8'd6},
    // R7 global overrides byte controls; R11 no drive after write
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b11,1'b0,1'b0,6'd10,16'h5555,1'b0,16'h0000,8'd11},
    // R3 blocked processor strobe, then burst continues to 11
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b0,16'h0000,8'd3},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b1,16'h4444,8'd3},
    // R4 controller strobe with master off deselects
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd8, 16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd10,16'h0000,1'b1,16'h5555,8'd7},
    // R4 active-high select off
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd8, 16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd11,16'h0000,1'b1,16'h4444,8'd2},
    // R4 active-low select off on processor strobe
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd8, 16'h0000,1'b0,16'h0000,8'd4},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,6'd0, 16'h0000,1'b0,16'h0000,8'd4},
    // R8 high byte only at 11
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,1'b0,1'b0,6'd11,16'h9900,1'b0,16'h0000,8'd8},
    // R9 gate high: byte enables ignored, read
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,6'd11,16'hFFFF,1'b1,16'h9944,8'd9},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,6'd11,16'h0000,1'b1,16'h9944,8'd9},
    // R10 read with output enable off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b1,6'd8, 16'h0000,1'b0,16'h0000,8'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr;
  logic stb_cpu_n, stb_ctl_n, sel_main_n, sel_hi, sel_lo_n, adv_n;
  logic wr_all_n, wr_gate_n, order_ilv, oe_n;
  logic [1:0] wr_byte_n;
  logic [15:0] wr_data, rd_data;
  logic rd_drive;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sbsram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
    .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .wr_byte_n(wr_byte_n),
    .order_ilv(order_ilv), .oe_n(oe_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic apply(input vec_t v);
    stb_cpu_n = v.ps_n; stb_ctl_n = v.cs_n; sel_main_n = v.m_n; sel_hi = v.hi;
    sel_lo_n = v.lo_n; adv_n = v.adv_n; wr_all_n = v.gw_n; wr_gate_n = v.gate_n;
    wr_byte_n = v.bw_n; order_ilv = v.ilv; oe_n = v.oe_n; addr = v.a; wr_data = v.d;
  endtask

  task automatic check(input int req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: got drive/data %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [16:0] seen();
    return {rd_drive, rd_drive ? rd_data : 16'h0000};
  endfunction

  localparam vec_t IDLE = '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,
                            6'd0,16'h0000,1'b0,16'h0000,8'd0};

  initial begin
    apply(IDLE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, seen(), 17'h0);                 // R1 reset state
    adv_n = 1'b0;                            // R1 advance without a burst
    @(negedge clk);
    check(1, seen(), 17'h0);
    apply(IDLE);
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check(int'(VEC[i].req), seen(), {VEC[i].eoe, VEC[i].eoe ? VEC[i].ed : 16'h0000});
    end
    oe_n = 1'b0; #1;                         // R10 enable without a clock edge
    check(10, seen(), {1'b1, 16'h1111});
    oe_n = 1'b1; #1;
    check(10, seen(), 17'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule